// File: doc/BRIEF.md
# Dual-Compare 16-bit Interval Timer

A 16-bit up-counter with two compare channels, each raising a one-cycle interrupt when the counter reaches that channel's compare value. Channel 0 also sets the period: after the counter has sat at the channel-0 value for one count tick, the next tick returns it to zero. The count tick comes from one of three internal rates or from an external event pin. The internal rates are the system clock, the system clock divided by two and the system clock divided by four, and both dividers are built inside the block. For external events, two input pins are synchronized and edge-detected, and a select bit picks which of them drives the counter.

Software programs the block through a small write port with three addresses: a control word, compare 0 and compare 1. It reads the counter on a dedicated read output. Compare values never act directly. Each channel matches against a hidden buffer. While the timer is stopped, the buffer follows the compare register. While it runs, the buffer is reloaded only when a channel-0 match clears the counter, so a new period starts cleanly at a period boundary.

When the timer is stopped, the counter rests at all-ones but reads back as zero.

Top module: `tmr_dual_cmp`

## Requirements
- R1: After reset `rd_count` is 0000H, both `irq` bits are low, and both buffers are 0000H. Enabling without any compare write then gives counter 0 and both interrupts on the first tick.
- R2: While the enable bit is 0, the counter is held at FFFFH, `rd_count` reads 0000H and no interrupt is raised. After an enable, `rd_count` shows FFFFH until the first tick.
- R3: Control field `src` (bits 2:1) selects the tick: 0 gives every clock, 1 gives every 2nd clock, 2 gives every 4th clock, 3 gives external events. After enable, the n-th tick of rates 1 and 2 lands on clock 2n and clock 4n.
- R4: Each pin has a 2-bit edge mode, pin 0 in bits 5:4 and pin 1 in bits 7:6: 0 counts no edge, 1 rising edges, 2 falling edges, 3 both edges. Bit 3 selects the pin that drives the counter. Each valid edge on the selected pin advances the counter exactly once, after a two-flop synchronizer.
- R5: The enable is bit 0 of the control word. On the first tick after enable the counter goes from FFFFH to 0000H, and each later tick adds one.
- R6: On a tick while the counter equals the channel-0 buffer, the counter returns to 0000H, so the period is buffer+1 ticks.
- R7: Channel i's `irq[i]` is high for exactly the one clock that follows a tick which brought the counter equal to that channel's buffer.
- R8: Writes go to address 0 (control), 1 (compare 0) and 2 (compare 1). A compare written while the timer is stopped takes effect from the first period.
- R9: A compare written while the timer runs takes effect only from the next channel-0 clear. Until then, both channels keep matching their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare 0, 2 compare 1 |
| wr_data | input | 16 | Write data |
| ev_in | input | 2 | Asynchronous external event pins |
| rd_count | output | 16 | Counter read value (0 while stopped) |
| irq | output | 2 | Per-channel compare-match pulses |

## Verification
Several properties are checked on every cycle:
- the counter rests at all-ones while stopped;
- an interrupt only follows a tick, with the counter equal to that channel's buffer;
- a running buffer changes only at a channel-0 clear, and a stopped buffer tracks its compare register;
- a channel-0 match clears the counter;
- the quarter-rate tick never repeats on adjacent cycles;
- a pin in the no-edge mode never produces a pulse.

Only the bench scenarios can show the following:
- the exact tick rates and the cycle at which the first tick lands;
- the edge counts for each detector mode and pin selection;
- the period length;
- the deferral of a compare write made mid-period to the next boundary.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int NUM_CH  = 2;
    localparam int NUM_PIN = 2;
    localparam int ADDR_W  = 2;
    localparam int PRE_W   = 2;

    // Count source: three internal rates or external events
    typedef enum logic [1:0] {
        CS_BASE  = 2'd0,
        CS_HALF  = 2'd1,
        CS_QUART = 2'd2,
        CS_EVENT = 2'd3
    } clk_sel_e;

    // Bit 0 enables rising edges, bit 1 enables falling edges
    typedef enum logic [1:0] {
        EM_OFF  = 2'd0,
        EM_RISE = 2'd1,
        EM_FALL = 2'd2,
        EM_ANY  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        edge_mode_e edge_b;   // [7:6] pin 1
        edge_mode_e edge_a;   // [5:4] pin 0
        logic       pin_sel;  // [3]
        clk_sel_e   src;      // [2:1]
        logic       run;      // [0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

    function automatic logic [ADDR_W-1:0] cmp_addr(input int ch);
        return ADDR_W'(ch + 1);
    endfunction

    function automatic logic rate_tick(input clk_sel_e src, input logic [PRE_W-1:0] ph);
        case (src)
            CS_BASE:  return 1'b1;
            CS_HALF:  return ph[0];
            CS_QUART: return &ph[1:0];
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_sel_e src,
    output logic     tick_o
);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run) ph_q <= '0;
        else             ph_q <= ph_q + 1'b1;
    end

    assign tick_o = run && rate_tick(src, ph_q[PRE_W-1:0]);

    // R3: quarter rate never ticks on two adjacent cycles
    p_quarter_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && src == CS_QUART) |=> !(tick_o && src == CS_QUART));

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       pulse_o
);

    // [0],[1] synchronizer stages, [2] previous synchronized value
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], pin};
    end

    logic rise, fall;
    assign rise    = sh_q[1] & ~sh_q[2];
    assign fall    = ~sh_q[1] & sh_q[2];
    assign pulse_o = (rise & mode[0]) | (fall & mode[1]);

    // R4: no-edge mode never yields an event
    p_off_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == EM_OFF) |-> !pulse_o);

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         reload,
    input  logic [W-1:0] cnt_cur,
    input  logic [W-1:0] cnt_nxt,
    output logic [W-1:0] buf_o,
    output logic         irq_o
);

    logic [W-1:0] cmp_q, cmp_d, buf_q, buf_d;

    always_comb begin
        cmp_d = wr ? wdata : cmp_q;
        if (!run)        buf_d = cmp_d;
        else if (reload) buf_d = cmp_q;
        else             buf_d = buf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            buf_q <= '0;
            irq_o <= 1'b0;
        end else begin
            cmp_q <= cmp_d;
            buf_q <= buf_d;
            irq_o <= run && tick && (cnt_nxt == buf_d);
        end
    end

    assign buf_o = buf_q;

    // R7: a pulse always coincides with counter equal to buffer
    p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cnt_cur == buf_q));

    // R9: a running buffer changes only at a channel-0 clear
    p_buf_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(reload)) |-> $stable(buf_q));

    // R8: a stopped buffer follows its compare register
    p_buf_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (buf_q == cmp_q));

endmodule

// File: rtl/tmr_dual_cmp.sv
module tmr_dual_cmp
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_PIN-1:0] ev_in,
    output logic [CNT_W-1:0]  rd_count,
    output logic [NUM_CH-1:0] irq
);

    localparam logic [CNT_W-1:0] IDLE_VAL = '1;

    ctrl_t ctrl_q;
    logic  run;

    always_ff @(posedge clk) begin
        if (rst)                               ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    assign run = ctrl_q.run;

    // Internal rate
    logic tick_int;
    tmr_prescale #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .src(ctrl_q.src), .tick_o(tick_int)
    );

    // External event detectors
    logic [NUM_PIN-1:0] ev_pulse;
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        edge_mode_e pm;
        assign pm = (p == 0) ? ctrl_q.edge_a : ctrl_q.edge_b;
        tmr_edge_det u_edge (
            .clk(clk), .rst(rst), .pin(ev_in[p]), .mode(pm), .pulse_o(ev_pulse[p])
        );
    end

    logic tick;
    assign tick = run && ((ctrl_q.src == CS_EVENT) ? ev_pulse[ctrl_q.pin_sel] : tick_int);

    // Counter
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] buf_v [NUM_CH];
    logic             period_end;

    assign period_end = run && tick && (cnt_q == buf_v[0]);

    always_comb begin
        if (!run)            cnt_d = IDLE_VAL;
        else if (period_end) cnt_d = '0;
        else if (tick)       cnt_d = cnt_q + 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= IDLE_VAL;
        else     cnt_q <= cnt_d;
    end

    // Compare channels
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_cmp_chan #(.W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .run(run), .tick(tick),
            .wr(wr_en && wr_addr == cmp_addr(c)), .wdata(wr_data),
            .reload(period_end), .cnt_cur(cnt_q), .cnt_nxt(cnt_d),
            .buf_o(buf_v[c]), .irq_o(irq[c])
        );

        // R7: a pulse only follows a tick
        p_irq_tick_r7: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> $past(tick));
    end

    assign rd_count = run ? cnt_q : '0;

    // R2: counter rests at all-ones while stopped
    p_idle_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(!run)) |-> (cnt_q == IDLE_VAL));

    // R6: channel-0 match clears on the following tick
    p_period_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && $past(tick) && $past(cnt_q == buf_v[0])) |-> (cnt_q == '0));

endmodule

// File: tb/test_tmr_dual_cmp.sv
`timescale 1ns/1ps
module test_tmr_dual_cmp;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  ev_in;
    logic [15:0] rd_count;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_dual_cmp i_tmr_dual_cmp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_in(ev_in), .rd_count(rd_count), .irq(irq)
    );

    function automatic logic [15:0] ctl(input bit en, input bit [1:0] src,
                                        input bit pin, input bit [1:0] e0, input bit [1:0] e1);
        return {8'h00, e1, e0, pin, src, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Drive at a negedge, captured at the following posedge; returns at the next negedge
    task automatic wr(input bit [1:0] a, input bit [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop();
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_reset();
        chk(rd_count == 16'h0000, "R1 reset read", rd_count, 0);
        chk(irq == 2'b00, "R1 reset irq", irq, 0);
        wr(2'd0, ctl(1, 2'd0, 0, 0, 0));
        step();
        chk(rd_count == 16'h0000, "R1 zero buffers count", rd_count, 0);
        chk(irq == 2'b11, "R1 zero buffers irq", irq, 3);
        stop();
        step();
        chk(rd_count == 16'h0000 && irq == 2'b00, "R2 stopped read", rd_count, 0);
    endtask

    task automatic t_base_rate();
        int bad_cnt = 0, n0 = 0, n1 = 0, bad_pair = 0;
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd4);
        wr(2'd0, ctl(1, 2'd0, 0, 0, 0));
        chk(rd_count == 16'hFFFF, "R2 idle value before first tick", rd_count, 16'hFFFF);
        for (int k = 1; k <= 30; k++) begin
            step();
            if (rd_count != 16'((k - 1) % 10)) bad_cnt++;
            if (irq[0]) n0++;
            if (irq[1]) n1++;
            if (irq[0] != (rd_count == 16'd9)) bad_pair++;
        end
        chk(bad_cnt == 0, "R5 R6 base-rate sequence", bad_cnt, 0);
        chk(n0 == 3, "R7 channel 0 pulses", n0, 3);
        chk(n1 == 3, "R7 channel 1 pulses", n1, 3);
        chk(bad_pair == 0, "R7 pulse aligned with match", bad_pair, 0);
        stop();
        step();
        chk(rd_count == 16'h0000 && irq == 2'b00, "R2 read zero after stop", rd_count, 0);
    endtask

    task automatic t_divided(input bit [1:0] src, input int div);
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(1, src, 0, 0, 0));
        for (int k = 1; k <= 20; k++) begin
            step();
            if (k == div - 1)
                chk(rd_count == 16'hFFFF, "R3 no tick before divider", rd_count, 16'hFFFF);
            if (k == div)
                chk(rd_count == 16'h0000, "R3 R5 first divided tick", rd_count, 0);
        end
        chk(rd_count == 16'(20 / div - 1), "R3 divided rate", rd_count, 20 / div - 1);
        stop();
    endtask

    task automatic t_events(input bit pin, input bit [1:0] e0, input bit [1:0] e1,
                            input int npulse, input bit drive_pin, input int exp, input string req);
        wr(2'd1, 16'd1000);
        wr(2'd0, ctl(1, 2'd3, pin, e0, e1));
        for (int n = 0; n < npulse; n++) begin
            step(); ev_in[drive_pin] = 1'b1;
            repeat (4) step();
            ev_in[drive_pin] = 1'b0;
            repeat (4) step();
        end
        repeat (4) step();
        chk(rd_count == 16'(exp), req, rd_count, exp);
        stop();
    endtask

    task automatic t_defer();
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd3);
        wr(2'd0, ctl(1, 2'd0, 0, 0, 0));
        for (int k = 1; k <= 20; k++) begin
            step();
            if (k == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd5; end
            if (k == 4) begin wr_addr = 2'd2; wr_data = 16'd1; end
            if (k == 5) wr_en = 1'b0;
            if (k == 4)  chk(irq[1] == 1'b1, "R9 old channel 1 value still used", irq, 2);
            if (k == 10) chk(rd_count == 16'd9, "R9 old period kept", rd_count, 9);
            if (k == 11) chk(rd_count == 16'd0, "R6 clear at old period", rd_count, 0);
            if (k == 12) chk(irq[1] == 1'b1, "R9 new channel 1 value", irq, 2);
            if (k == 14) chk(irq[1] == 1'b0, "R9 old channel 1 value gone", irq, 0);
            if (k == 16) chk(rd_count == 16'd5 && irq[0], "R9 new period top", rd_count, 5);
            if (k == 17) chk(rd_count == 16'd0, "R9 new period clear", rd_count, 0);
        end
        stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ev_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base_rate();
        t_divided(2'd1, 2);
        t_divided(2'd2, 4);
        t_events(0, 2'd1, 2'd0, 5, 0, 4, "R4 rising edges");
        t_events(0, 2'd2, 2'd0, 5, 0, 4, "R4 falling edges");
        t_events(0, 2'd3, 2'd0, 5, 0, 9, "R4 both edges");
        t_events(0, 2'd0, 2'd0, 5, 0, 16'hFFFF, "R4 no-edge mode");
        t_events(1, 2'd3, 2'd0, 3, 0, 16'hFFFF, "R4 unselected pin ignored");
        t_events(1, 2'd0, 2'd1, 3, 1, 2, "R4 pin 1 rising R3 event source");
        t_defer();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule